// File: doc/BRIEF.md
# Masked-Address GPIO Port

This block is an eight-line general-purpose I/O port that hangs off a simple byte-wide register bus with a valid strobe and a write flag. It holds one direction bit and one output value bit per line. It drives output values and output enables toward the pads, and it takes in pad input values through a two-flop synchroniser.

The output data is reached through a window of addresses in the lower half of the address space. The address of a data access carries a pin mask: byte-address bit n+2 selects line n. A write changes only the selected lines. A read returns zero for every unselected line. Software can therefore set, clear or sample any subset of lines in a single bus access, with no read-modify-write and no lock around shared state.

The direction byte sits at a fixed address in the upper half of the space. Read data is registered. It appears on the cycle after the access and holds until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: After synchronous reset (rstN low at a clock edge), padOut and padOe are 0x00, busRdata is 0x00, and a read of the direction byte returns 0x00 (all lines inputs).
- R2: A write with busAddr[10]=0 sets output bit n to busWdata[n] for each n whose mask bit busAddr[n+2] is 1. All other output bits keep their value.
- R3: A read with busAddr[10]=0 places the line values on busRdata on the cycle after the access. Every bit whose mask bit busAddr[n+2] is 0 reads as 0.
- R4: In a masked data read, line n returns its output value when its direction bit is 1. It returns the synchronised pad input when its direction bit is 0.
- R5: The direction byte at address 0x400 reads back exactly as written. A direction bit of 1 makes the line an output, and padOe equals the direction byte.
- R6: Writing an output value while a line is an input updates padOut but not padOe. The value is driven as soon as the direction bit becomes 1.
- R7: A pad input change passes through two flops. A read issued in the same cycle as the change, or in the next cycle, returns the old value. A read issued two cycles after the change returns the new value.
- R8: Accesses with busAddr[10]=1 and an address other than 0x400 have no effect on the outputs or the direction, and reads of them return 0x00.
- R9: busRdata holds its last value on cycles without a read access, including write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 11 | Byte address; bits [9:2] form the data mask |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| padIn | input | 8 | Pad input values, asynchronous |
| padOut | output | 8 | Output values toward pads |
| padOe | output | 8 | Output enables, 1 = drive |

## Verification
Masked writes use single-bit, multi-bit, full and empty masks with data that disagrees with the mask. This separates the per-pin merge from whole-byte writes and from a merge that leaks the data of unmasked bits. Masked reads run over mixed directions with output and pad values set to opposite patterns, so a wrong source selection or a missing mask shows up in specific bits. Pad changes are read in the same cycle, one cycle later and two cycles later, which pins down the synchroniser depth. Stray accesses in the upper half and idle or write cycles between reads show whether unused decodes and the read-data register leak.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int PINS = 8;

  typedef struct packed {
    logic            dataWr;
    logic            dataRd;
    logic            dirWr;
    logic            dirRd;
    logic            nullRd;
    logic [PINS-1:0] mask;
  } gpioCtl_t;
endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter logic [10:0] DIR_ADDR = 11'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioCtl_t          ctl
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + PINS - 1;

  logic inWindow;
  logic isDir;

  assign inWindow = ~busAddr[ADDR_W-1];
  assign isDir    = (busAddr == DIR_ADDR[ADDR_W-1:0]);

  always_comb begin
    ctl        = '0;
    ctl.mask   = busAddr[MASK_HI:MASK_LO];
    ctl.dataWr = busValid & busWrite & inWindow;
    ctl.dataRd = busValid & ~busWrite & inWindow;
    ctl.dirWr  = busValid & busWrite & isDir;
    ctl.dirRd  = busValid & ~busWrite & isDir;
    ctl.nullRd = busValid & ~busWrite & ~inWindow & ~isDir;
  end

  // R8: at most one strobe per access
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.dataWr, ctl.dataRd, ctl.dirWr, ctl.dirRd, ctl.nullRd}));
endmodule

// File: rtl/gpio_mask_dp.sv
module gpio_mask_dp
  import gpio_mask_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  gpioCtl_t        ctl,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] outVal,
  output logic [PINS-1:0] dirVal
);
  logic [PINS-1:0] syncA;
  logic [PINS-1:0] syncB;
  logic [PINS-1:0] pinView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outVal[n] <= 1'b0;
      end else if (ctl.dataWr && ctl.mask[n]) begin
        outVal[n] <= wdata[n];
      end
    end
    assign pinView[n] = dirVal[n] ? outVal[n] : syncB[n];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirVal <= '0;
    end else if (ctl.dirWr) begin
      dirVal <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (ctl.dataRd) begin
      rdata <= pinView & ctl.mask;
    end else if (ctl.dirRd) begin
      rdata <= dirVal;
    end else if (ctl.nullRd) begin
      rdata <= '0;
    end
  end

  p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataWr |=> ((outVal ^ $past(outVal)) & ~$past(ctl.mask)) == '0);
  p_unmasked_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataRd |=> (rdata & ~$past(ctl.mask)) == '0);
  p_dir_readback_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dirWr |=> dirVal == $past(wdata));
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.dataRd || ctl.dirRd || ctl.nullRd) |=> $stable(rdata));
  p_null_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nullRd |=> (rdata == '0) && $stable(dirVal) && $stable(outVal));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [10:0] busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic [7:0]  padIn,
  output logic [7:0]  padOut,
  output logic [7:0]  padOe
);
  gpioCtl_t ctl;

  gpio_mask_ctrl #(.ADDR_W(11), .DIR_ADDR(11'h400)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .ctl      (ctl)
  );

  gpio_mask_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wdata  (busWdata),
    .padIn  (padIn),
    .rdata  (busRdata),
    .outVal (padOut),
    .dirVal (padOe)
  );
endmodule

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [10:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] expOut = '0;
  logic [7:0] expDir = '0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  gpio_mask_port u_gpio_mask_port (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] dataAddr(input logic [7:0] m);
    return {1'b0, m, 2'b00};
  endfunction

  task automatic busWr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic maskedWr(input logic [7:0] m, input logic [7:0] d);
    busWr(dataAddr(m), d);
    expOut = (expOut & ~m) | (d & m);
  endtask

  function automatic logic [7:0] pinModel(input logic [7:0] m);
    return m & ((expDir & expOut) | (~expDir & padIn));
  endfunction

  task automatic t_reset();
    check("R1 padOut", padOut, 8'h00);
    check("R1 padOe", padOe, 8'h00);
    check("R1 busRdata", busRdata, 8'h00);
    busRd(11'h400, rd);
    check("R1 dir", rd, 8'h00);
  endtask

  task automatic t_masked_write();
    maskedWr(8'h01, 8'hFF); check("R2 single bit", padOut, expOut);
    maskedWr(8'hF0, 8'h5A); check("R2 upper nibble", padOut, expOut);
    maskedWr(8'h00, 8'hFF); check("R2 empty mask", padOut, expOut);
    maskedWr(8'hFF, 8'h3C); check("R2 full mask", padOut, expOut);
    maskedWr(8'h81, 8'h00); check("R2 two bits", padOut, expOut);
  endtask

  task automatic t_dir();
    busWr(11'h400, 8'hA5); expDir = 8'hA5;
    busRd(11'h400, rd);
    check("R5 readback", rd, 8'hA5);
    check("R5 padOe", padOe, 8'hA5);
  endtask

  task automatic t_masked_read();
    padIn = 8'hC3;
    repeat (3) @(negedge clk);
    busRd(dataAddr(8'hFF), rd); check("R4 full mask", rd, pinModel(8'hFF));
    busRd(dataAddr(8'h0F), rd); check("R3 low mask", rd, pinModel(8'h0F));
    busRd(dataAddr(8'h00), rd); check("R3 empty mask", rd, 8'h00);
    padIn = 8'h3C;
    repeat (3) @(negedge clk);
    busRd(dataAddr(8'hF0), rd); check("R4 high mask", rd, pinModel(8'hF0));
  endtask

  task automatic t_out_while_input();
    busWr(11'h400, 8'h00); expDir = 8'h00;
    maskedWr(8'h10, 8'h10);
    check("R6 padOut early", padOut, expOut);
    check("R6 padOe still off", padOe, 8'h00);
    busWr(11'h400, 8'h10); expDir = 8'h10;
    check("R6 driven", padOut & padOe, 8'h10);
  endtask

  task automatic t_sync();
    logic [7:0] r0, r1, r2;
    busWr(11'h400, 8'h00); expDir = 8'h00;
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    @(negedge clk);
    padIn = 8'hFF; busValid = 1'b1; busWrite = 1'b0; busAddr = dataAddr(8'hFF);
    @(negedge clk); r0 = busRdata;
    @(negedge clk); r1 = busRdata;
    @(negedge clk); r2 = busRdata;
    busValid = 1'b0;
    check("R7 same cycle", r0, 8'h00);
    check("R7 one later", r1, 8'h00);
    check("R7 two later", r2, 8'hFF);
  endtask

  task automatic t_stray();
    busRd(11'h400, rd);
    busWr(11'h404, 8'hFF);
    busWr(11'h7FC, 8'hFF);
    check("R8 padOe untouched", padOe, expDir);
    check("R8 padOut untouched", padOut, expOut);
    busRd(11'h5FC, rd);
    check("R8 stray read", rd, 8'h00);
  endtask

  task automatic t_hold();
    busRd(11'h400, rd);
    maskedWr(8'hFF, 8'h99);
    repeat (2) @(negedge clk);
    check("R9 hold", busRdata, expDir);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_masked_write();
        t_dir();
        t_masked_read();
        t_out_while_input();
        t_sync();
        t_stray();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule